// File: doc/BRIEF.md
# Flag Offset Programming Controller

This block sets the four threshold values that a pair of FIFOs use for their almost-empty and almost-full flags. Two offsets belong to the first FIFO (almost-empty `x1`, almost-full `y1`) and two to the second (almost-empty `x2`, almost-full `y2`). Three mode pins are captured while master reset is held. The last capture before release selects how the offsets are filled. There are three methods: a fixed preset, a parallel load from the first four accepted writes on the write stream, or a bit-serial load from a data pin gated by an active-low enable.

The write port is a valid/ready stream. A word is accepted on a write-clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is the first FIFO's input-ready flag, and it is the only source of back-pressure. While the parallel load is in progress, `load_divert` is high and accepted words go to the offset registers instead of RAM. After programming, accepted words appear on `ram_wr_valid` / `ram_wr_data` in the same cycle. The ready flag of the second FIFO (`rdy_c`) sits in its own clock domain. It is raised through a two-flop synchronizer once loading is done.

Master reset `rst_n` is active low and sampled synchronously by both clocks. The default depth is 256, which gives 8-bit offsets with a legal range of 1 to 252.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: With `prog_sel`=1, pin pairs (`fsel1_sen_n`,`fsel0_sdat`) of (1,1), (1,0) and (0,1) load 64, 16 and 8 into all four offsets. `wr_ready` is high after the first write-clock edge following reset release.
- R2: With `prog_sel`=0, pin pairs (0,0), (0,1) and (1,1) are reserved. They load 8 into all offsets, make `wr_ready` high after the first edge, and set `mode_err`. `mode_err` stays high until the next reset.
- R3: With `prog_sel`=1 and pins (0,0), the first four accepted writes load `y1`, `x1`, `y2`, `x2` in that order from `wr_data[OW-1:0]` (bit OW-1 is the MSB). `load_divert` is high and `ram_wr_valid` stays low for these writes.
- R4: Once programming is complete, every accepted write raises `ram_wr_valid` in the same cycle, with `ram_wr_data` equal to `wr_data`.
- R5: With `prog_sel`=0 and pins (1,0), serial mode is selected. `wr_ready` and `rdy_c` stay low until 4×OW bits have been captured. `wr_ready` rises on the write-clock edge that captures the last bit.
- R6: In serial mode, one bit of `fsel0_sdat` is captured per write-clock edge, MSB first, in the order `y1`, `x1`, `y2`, `x2`.
- R7: A serial bit is captured only on edges where `fsel1_sen_n` is low. Edges with it high, and any bits sent after the load is complete, leave the offsets unchanged.
- R8: `rdy_c` rises only after loading is done, via two `clk_c` flops. It is low on the first write edge after the load completes and high within a few `clk_c` cycles.
- R9: A loaded value of 0 is stored as 1, and a value above DEPTH-4 is stored as DEPTH-4. Either case sets `range_err`, which reset clears. Values from 1 to DEPTH-4 are stored as given.
- R10: While `rst_n` is low, `wr_ready`, `rdy_c` and `ram_wr_valid` are low, even if `wr_valid` is high.
- R11: After programming is done, the offsets hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-port clock |
| clk_c | input | 1 | Clock of the second FIFO's write side |
| rst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prog_sel | input | 1 | Mode pin: 1 = preset or parallel, 0 = serial or reserved |
| fsel1_sen_n | input | 1 | Mode pin during reset; serial enable (active low) afterwards |
| fsel0_sdat | input | 1 | Mode pin during reset; serial data afterwards |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready (first FIFO input-ready) |
| wr_data | input | DW | Write stream data |
| ram_wr_valid | output | 1 | Accepted write forwarded to RAM |
| ram_wr_data | output | DW | Data forwarded to RAM |
| load_divert | output | 1 | Accepted writes are being taken as offsets |
| rdy_c | output | 1 | Second FIFO input-ready, in the `clk_c` domain |
| ofs_y1 | output | OW | Almost-full offset, first FIFO |
| ofs_x1 | output | OW | Almost-empty offset, first FIFO |
| ofs_y2 | output | OW | Almost-full offset, second FIFO |
| ofs_x2 | output | OW | Almost-empty offset, second FIFO |
| mode_err | output | 1 | Sticky reserved-mode indication |
| range_err | output | 1 | Sticky out-of-range offset indication |

## Verification
Every mode-pin combination is applied from a table. This separates the three preset values and the reserved codes, and shows that the error flag clears on a later good reset.

The parallel load uses four distinct values, each with junk in the upper data bits. This proves both the register order and the field width. Idle cycles are placed between the writes so that only accepted words advance the sequence.

The serial load uses an asymmetric 32-bit pattern. Gaps with the enable high carry inverted data, which exposes any bit reversal, any register-order swap, or capture while the enable is high.

Clamping is tested at 0, 1, DEPTH-4 and just above it.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  typedef enum logic [2:0] {
    LM_PRE64 = 3'd0,
    LM_PRE16 = 3'd1,
    LM_PRE8  = 3'd2,
    LM_PAR   = 3'd3,
    LM_SER   = 3'd4,
    LM_RSV   = 3'd5
  } load_mode_e;

  // Register slot order shared by the parallel and serial paths.
  localparam int SLOT_Y1 = 0;
  localparam int SLOT_X1 = 1;
  localparam int SLOT_Y2 = 2;
  localparam int SLOT_X2 = 3;
  localparam int NSLOT   = 4;

  function automatic load_mode_e decode_mode(input logic psel,
                                             input logic f1,
                                             input logic f0);
    load_mode_e m;
    if (psel) begin
      case ({f1, f0})
        2'b11:   m = LM_PRE64;
        2'b10:   m = LM_PRE16;
        2'b01:   m = LM_PRE8;
        default: m = LM_PAR;
      endcase
    end else begin
      m = ({f1, f0} == 2'b10) ? LM_SER : LM_RSV;
    end
    return m;
  endfunction

  function automatic int preset_of(input load_mode_e m);
    int v;
    case (m)
      LM_PRE64: v = 64;
      LM_PRE16: v = 16;
      default:  v = 8;
    endcase
    return v;
  endfunction

  function automatic logic is_fixed(input load_mode_e m);
    return (m == LM_PRE64) || (m == LM_PRE16) || (m == LM_PRE8) || (m == LM_RSV);
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import ofs_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  load_mode_e live_mode,
  output load_mode_e mode_q,
  output logic       run_q
);

  // Mode follows the pins on every edge of reset; the last capture sticks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= live_mode;
      run_q  <= 1'b0;
    end else begin
      run_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_prog_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  load_mode_e            mode,
  input  logic                  acc,
  input  logic [W-1:0]          wr_field,
  input  logic                  sen_n,
  input  logic                  sd,
  output logic [NSLOT-1:0]      ld_en,
  output logic [NSLOT-1:0][W-1:0] ld_val,
  output logic                  done
);

  localparam int NBITS = NSLOT * W;
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(NBITS - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(NSLOT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [NBITS-1:0] sh_q;
  logic [NBITS-1:0] sh_nxt;
  logic             done_q;
  logic             par_active;
  logic             ser_active;
  logic             shift_fire;
  logic             ser_last;
  logic             par_fire;
  logic [1:0]       slot_idx;

  assign par_active = run && (mode == LM_PAR) && !done_q;
  assign ser_active = run && (mode == LM_SER) && !done_q;
  assign shift_fire = ser_active && !sen_n;
  assign ser_last   = shift_fire && (cnt_q == LAST_BIT);
  assign par_fire   = par_active && acc;
  assign sh_nxt     = {sh_q[NBITS-2:0], sd};
  assign slot_idx   = cnt_q[1:0];

  always_comb begin
    ld_en  = '0;
    ld_val = '0;
    if (par_fire) begin
      ld_en[slot_idx] = 1'b1;
      for (int i = 0; i < NSLOT; i++) ld_val[i] = wr_field;
    end else if (ser_last) begin
      ld_en = '1;
      // First bit shifted in lands at the top: slot 0 occupies the MSBs.
      for (int i = 0; i < NSLOT; i++) ld_val[i] = sh_nxt[NBITS-1-i*W -: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (is_fixed(mode) && !done_q) done_q <= 1'b1;
      if (par_fire) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST_WORD) done_q <= 1'b1;
      end
      if (shift_fire) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + CNT_W'(1);
        if (ser_last) done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_prog_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  load_mode_e              rst_mode,
  input  logic [NSLOT-1:0]        ld_en,
  input  logic [NSLOT-1:0][W-1:0] ld_val,
  output logic [NSLOT-1:0][W-1:0] ofs,
  output logic                    range_err
);

  localparam logic [W-1:0] MAXV = W'(DEPTH - 4);
  localparam logic [W-1:0] MINV = W'(1);

  logic [NSLOT-1:0] bad;
  logic [W-1:0]     preset_w;
  logic             err_q;

  assign preset_w = W'(preset_of(rst_mode));

  function automatic logic [W-1:0] clamp_val(input logic [W-1:0] v);
    if (v < MINV)      return MINV;
    else if (v > MAXV) return MAXV;
    else               return v;
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign bad[g] = ld_en[g] && ((ld_val[g] < MINV) || (ld_val[g] > MAXV));
    always_ff @(posedge clk) begin
      if (!rst_n)        ofs[g] <= preset_w;
      else if (ld_en[g]) ofs[g] <= clamp_val(ld_val[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    err_q <= 1'b0;
    else if (|bad) err_q <= 1'b1;
  end

  assign range_err = err_q;

endmodule

// File: rtl/ofs_sync2.sv
module ofs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
  import ofs_prog_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  localparam int OW   = $clog2(DEPTH)
) (
  input  logic          clk_a,
  input  logic          clk_c,
  input  logic          rst_n,
  input  logic          prog_sel,
  input  logic          fsel1_sen_n,
  input  logic          fsel0_sdat,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          ram_wr_valid,
  output logic [DW-1:0] ram_wr_data,
  output logic          load_divert,
  output logic          rdy_c,
  output logic [OW-1:0] ofs_y1,
  output logic [OW-1:0] ofs_x1,
  output logic [OW-1:0] ofs_y2,
  output logic [OW-1:0] ofs_x2,
  output logic          mode_err,
  output logic          range_err
);

  load_mode_e                live_mode;
  load_mode_e                mode_q;
  logic                      run_q;
  logic                      done_a;
  logic                      acc;
  logic                      merr_q;
  logic [NSLOT-1:0]          ld_en;
  logic [NSLOT-1:0][OW-1:0]  ld_val;
  logic [NSLOT-1:0][OW-1:0]  ofs;

  assign live_mode = decode_mode(prog_sel, fsel1_sen_n, fsel0_sdat);

  ofs_mode_latch u_mode (
    .clk       (clk_a),
    .rst_n     (rst_n),
    .live_mode (live_mode),
    .mode_q    (mode_q),
    .run_q     (run_q)
  );

  // Stream handshake and steering.
  assign wr_ready     = run_q && ((mode_q != LM_SER) || done_a);
  assign acc          = wr_valid && wr_ready;
  assign load_divert  = run_q && (mode_q == LM_PAR) && !done_a;
  assign ram_wr_valid = acc && !load_divert;
  assign ram_wr_data  = wr_data;

  ofs_load_seq #(.W(OW)) u_seq (
    .clk      (clk_a),
    .rst_n    (rst_n),
    .run      (run_q),
    .mode     (mode_q),
    .acc      (acc),
    .wr_field (wr_data[OW-1:0]),
    .sen_n    (fsel1_sen_n),
    .sd       (fsel0_sdat),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .done     (done_a)
  );

  ofs_bank #(.W(OW), .DEPTH(DEPTH)) u_bank (
    .clk       (clk_a),
    .rst_n     (rst_n),
    .rst_mode  (live_mode),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .ofs       (ofs),
    .range_err (range_err)
  );

  ofs_sync2 u_sync_c (
    .clk   (clk_c),
    .rst_n (rst_n),
    .d     (done_a),
    .q     (rdy_c)
  );

  always_ff @(posedge clk_a) begin
    if (!rst_n)                  merr_q <= 1'b0;
    else if (mode_q == LM_RSV)   merr_q <= 1'b1;
  end

  assign mode_err = merr_q;
  assign ofs_y1   = ofs[SLOT_Y1];
  assign ofs_x1   = ofs[SLOT_X1];
  assign ofs_y2   = ofs[SLOT_Y2];
  assign ofs_x2   = ofs[SLOT_X2];

endmodule

// File: rtl/ofs_prog_ctrl_chk.sv
module ofs_prog_ctrl_chk
  import ofs_prog_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input logic         clk_a,
  input logic         clk_c,
  input logic         rst_n,
  input logic         wr_ready,
  input logic         ram_wr_valid,
  input logic         load_divert,
  input logic         rdy_c,
  input logic         done_a,
  input load_mode_e   mode_q,
  input logic         mode_err,
  input logic [W-1:0] ofs_y1,
  input logic [W-1:0] ofs_x1,
  input logic [W-1:0] ofs_y2,
  input logic [W-1:0] ofs_x2
);

  localparam logic [W-1:0] MAXV = W'(DEPTH - 4);

  AST_RESET_READY_LOW: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(rst_n) |-> !wr_ready && !ram_wr_valid); // R10

  AST_OFS_FROZEN: assert property (@(posedge clk_a) disable iff (!rst_n)
    (done_a && $past(done_a)) |-> $stable({ofs_y1, ofs_x1, ofs_y2, ofs_x2})); // R11

  AST_RDY_C_FOLLOWS: assert property (@(posedge clk_c) disable iff (!rst_n)
    rdy_c |-> done_a); // R8

  AST_OFS_IN_RANGE: assert property (@(posedge clk_a) disable iff (!rst_n)
    done_a |-> (ofs_y1 != '0) && (ofs_x1 != '0) && (ofs_y2 != '0) && (ofs_x2 != '0)
               && (ofs_y1 <= MAXV) && (ofs_x1 <= MAXV) && (ofs_y2 <= MAXV) && (ofs_x2 <= MAXV)); // R9

  AST_MODE_ERR_STICKY: assert property (@(posedge clk_a) disable iff (!rst_n)
    $past(mode_err) |-> mode_err); // R2

  AST_SERIAL_HOLD: assert property (@(posedge clk_a) disable iff (!rst_n)
    (mode_q == LM_SER && !done_a) |-> !wr_ready); // R5

  AST_RAM_AFTER_DONE: assert property (@(posedge clk_a) disable iff (!rst_n)
    ram_wr_valid |-> done_a); // R4

  AST_DIVERT_MODE: assert property (@(posedge clk_a) disable iff (!rst_n)
    load_divert |-> (mode_q == LM_PAR) && !ram_wr_valid); // R3

endmodule

bind ofs_prog_ctrl ofs_prog_ctrl_chk #(.W(OW), .DEPTH(DEPTH)) u_chk (
  .clk_a        (clk_a),
  .clk_c        (clk_c),
  .rst_n        (rst_n),
  .wr_ready     (wr_ready),
  .ram_wr_valid (ram_wr_valid),
  .load_divert  (load_divert),
  .rdy_c        (rdy_c),
  .done_a       (done_a),
  .mode_q       (mode_q),
  .mode_err     (mode_err),
  .ofs_y1       (ofs_y1),
  .ofs_x1       (ofs_x1),
  .ofs_y2       (ofs_y2),
  .ofs_x2       (ofs_x2)
);

// File: tb/tb_ofs_prog_ctrl.sv
module tb_ofs_prog_ctrl;

  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_C_PERIOD = 14;
  localparam int DEPTH = 256;
  localparam int DW    = 36;
  localparam int OW    = 8;

  // {prog_sel, f1, f0, expected offset[7:0], expected mode_err}
  localparam logic [11:0] VEC [7] = '{
    {3'b111, 8'd64, 1'b0},
    {3'b110, 8'd16, 1'b0},
    {3'b101, 8'd8,  1'b0},
    {3'b000, 8'd8,  1'b1},
    {3'b001, 8'd8,  1'b1},
    {3'b011, 8'd8,  1'b1},
    {3'b111, 8'd64, 1'b0}
  };

  logic          clk_a = 1'b0;
  logic          clk_c = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_sel = 1'b1;
  logic          fsel1_sen_n = 1'b1;
  logic          fsel0_sdat = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          ram_wr_valid;
  logic [DW-1:0] ram_wr_data;
  logic          load_divert;
  logic          rdy_c;
  logic [OW-1:0] ofs_y1, ofs_x1, ofs_y2, ofs_x2;
  logic          mode_err;
  logic          range_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_C_PERIOD/2) clk_c = ~clk_c;

  ofs_prog_ctrl #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk_a        (clk_a),
    .clk_c        (clk_c),
    .rst_n        (rst_n),
    .prog_sel     (prog_sel),
    .fsel1_sen_n  (fsel1_sen_n),
    .fsel0_sdat   (fsel0_sdat),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .ram_wr_valid (ram_wr_valid),
    .ram_wr_data  (ram_wr_data),
    .load_divert  (load_divert),
    .rdy_c        (rdy_c),
    .ofs_y1       (ofs_y1),
    .ofs_x1       (ofs_x1),
    .ofs_y2       (ofs_y2),
    .ofs_x2       (ofs_x2),
    .mode_err     (mode_err),
    .range_err    (range_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ofs(input string req, input logic [OW-1:0] y1, input logic [OW-1:0] x1,
                           input logic [OW-1:0] y2, input logic [OW-1:0] x2);
    check({req, " y1"}, 64'(ofs_y1), 64'(y1));
    check({req, " x1"}, 64'(ofs_x1), 64'(x1));
    check({req, " y2"}, 64'(ofs_y2), 64'(y2));
    check({req, " x2"}, 64'(ofs_x2), 64'(x2));
  endtask

  // Reset with mode pins; R10 checked while reset is held with wr_valid high.
  task automatic do_reset(input logic p, input logic f1, input logic f0);
    @(negedge clk_a);
    rst_n = 1'b0; prog_sel = p; fsel1_sen_n = f1; fsel0_sdat = f0;
    wr_valid = 1'b1; wr_data = '1;
    repeat (4) @(negedge clk_a);
    check("R10 wr_ready in reset", 64'(wr_ready), 64'd0);
    check("R10 rdy_c in reset", 64'(rdy_c), 64'd0);
    check("R10 ram_wr_valid in reset", 64'(ram_wr_valid), 64'd0);
    wr_valid = 1'b0;
    @(negedge clk_a);
    rst_n = 1'b1;
    @(posedge clk_a); #1;
  endtask

  // One write attempt; reports combinational outputs seen before the edge.
  task automatic push(input logic [DW-1:0] d, output logic ram_seen, output logic div_seen);
    @(negedge clk_a);
    wr_valid = 1'b1; wr_data = d;
    #1;
    ram_seen = ram_wr_valid;
    div_seen = load_divert;
    @(posedge clk_a); #1;
    @(negedge clk_a);
    wr_valid = 1'b0;
  endtask

  task automatic wait_rdy_c(input string req);
    for (int k = 0; k < 12 && !rdy_c; k++) begin
      @(posedge clk_a); #1;
    end
    check(req, 64'(rdy_c), 64'd1);
  endtask

  initial begin
    #(CLK_A_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic rs, dv;
    logic [31:0] sval;

    // Table-driven mode decode: presets and reserved codes (R1, R2).
    for (int i = 0; i < 7; i++) begin
      do_reset(VEC[i][11], VEC[i][10], VEC[i][9]);
      check_ofs("R1/R2 preset", VEC[i][8:1], VEC[i][8:1], VEC[i][8:1], VEC[i][8:1]);
      check("R1 wr_ready after release", 64'(wr_ready), 64'd1);
      check("R2 mode_err", 64'(mode_err), 64'(VEC[i][0]));
      check("R8 rdy_c not yet", 64'(rdy_c), 64'd0);
      check("R9 range_err clear", 64'(range_err), 64'd0);
      wait_rdy_c("R8 rdy_c rises");
    end

    // Parallel load, order and field width (R3), then pass-through (R4).
    do_reset(1'b1, 1'b0, 1'b0);
    check("R3 divert after release", 64'(load_divert), 64'd1);
    push({28'hFACE123, 8'd10}, rs, dv);
    check("R3 word0 not to RAM", 64'(rs), 64'd0);
    @(negedge clk_a);
    push({28'h0000001, 8'd20}, rs, dv);
    check("R3 word1 not to RAM", 64'(rs), 64'd0);
    push({28'hFFFFFFF, 8'd30}, rs, dv);
    check("R3 word2 divert", 64'(dv), 64'd1);
    check("R8 rdy_c low before last word", 64'(rdy_c), 64'd0);
    @(negedge clk_a); @(negedge clk_a);
    push({28'h8000000, 8'd40}, rs, dv);
    check("R3 word3 not to RAM", 64'(rs), 64'd0);
    check_ofs("R3 order", 8'd10, 8'd20, 8'd30, 8'd40);
    check("R3 divert ends", 64'(load_divert), 64'd0);
    check("R9 no range error", 64'(range_err), 64'd0);
    @(negedge clk_a);
    wr_valid = 1'b1; wr_data = 36'h123456789;
    #1;
    check("R4 ram_wr_valid", 64'(ram_wr_valid), 64'd1);
    check("R4 ram_wr_data", 64'(ram_wr_data), 64'h123456789);
    @(posedge clk_a); #1;
    wr_valid = 1'b0;
    check_ofs("R11 frozen after pass-through", 8'd10, 8'd20, 8'd30, 8'd40);
    wait_rdy_c("R8 rdy_c after parallel");

    // Clamping (R9).
    do_reset(1'b1, 1'b0, 1'b0);
    push({28'h0, 8'd1}, rs, dv);
    check("R9 value 1 accepted without error", 64'(range_err), 64'd0);
    push({28'h0, 8'd0}, rs, dv);
    check("R9 zero flags error", 64'(range_err), 64'd1);
    push({28'h0, 8'd253}, rs, dv);
    push({28'h0, 8'd252}, rs, dv);
    check_ofs("R9 clamp", 8'd1, 8'd1, 8'd252, 8'd252);
    check("R9 range_err sticky", 64'(range_err), 64'd1);

    // Serial load (R5, R6, R7).
    sval = {8'd165, 8'd3, 8'd200, 8'd7};
    do_reset(1'b0, 1'b1, 1'b0);
    check("R5 wr_ready low in serial", 64'(wr_ready), 64'd0);
    check("R9 range_err cleared by reset", 64'(range_err), 64'd0);
    for (int i = 0; i < 32; i++) begin
      if (i % 5 == 2) begin
        @(negedge clk_a);
        fsel1_sen_n = 1'b1; fsel0_sdat = ~sval[31-i];
        @(posedge clk_a); #1;
      end
      @(negedge clk_a);
      fsel1_sen_n = 1'b0; fsel0_sdat = sval[31-i];
      if (i == 16) begin
        wr_valid = 1'b1; #1;
        check("R5 no RAM write while shifting", 64'(ram_wr_valid), 64'd0);
        wr_valid = 1'b0;
      end
      if (i == 31) begin
        #1;
        check("R5 wr_ready low before last bit", 64'(wr_ready), 64'd0);
        check("R5 rdy_c low before last bit", 64'(rdy_c), 64'd0);
      end
      @(posedge clk_a); #1;
    end
    check("R5 wr_ready after last bit", 64'(wr_ready), 64'd1);
    check_ofs("R6 serial order", 8'd165, 8'd3, 8'd200, 8'd7);
    check("R8 rdy_c still low", 64'(rdy_c), 64'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a);
      fsel1_sen_n = 1'b0; fsel0_sdat = 1'b1;
      @(posedge clk_a); #1;
    end
    @(negedge clk_a);
    fsel1_sen_n = 1'b1;
    check_ofs("R7 extra bits ignored", 8'd165, 8'd3, 8'd200, 8'd7);
    wait_rdy_c("R8 rdy_c after serial");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule